// File: doc/BRIEF.md
# Emulated Floppy Drive Bit Streamer

This block takes the place of a mechanical floppy drive next to a floppy disk controller. It emulates a disk that spins at a fixed speed with a track of exactly fixed length. While the drive is spinning and selected, it moves one data bit per bit period. In read mode the bit goes to the controller. In write mode the bit comes from the controller. A host processor supplies and collects the raw track data through a wide interchange word. A request line tells the host when that word must be serviced.

For reads, the host preloads the first word while the drive is stopped. After that it refills a buffer word each time the request rises. The buffer is copied into the shifter at every word boundary. For writes, each completed word is captured for the host at the word boundary, and the same request line rises. The block also models the drive-side controls:
- head stepping with a direction input
- a track-zero flag
- a once-per-revolution index pulse
- a side select that is reported back to the host

With the default parameters, a 32 MHz clock gives 4 µs bits, 50000 bits per track and a 128-bit word.

Top module: `floppy_bit_streamer`

## Requirements
- R1: While running (motorOn and driveSel both high), exactly one bit period elapses every CYCLES_PER_BIT clock cycles. The first bit period ends CYCLES_PER_BIT rising edges after running begins. In read mode, rdBit presents the interchange word most significant bit first and moves to the next bit at the end of each bit period.
- R2: While not running, the bit position, the word bit count and the bit phase do not advance. The phase restarts from zero when running resumes.
- R3: The track bit position bitPos counts 0 to TRACK_BITS-1 and then wraps to 0, advancing by one per bit period.
- R4: index is high exactly while running and bitPos < INDEX_BITS, and low otherwise.
- R5: After REG_BITS bit periods of a word, the buffer word is moved into the shifter and irq is set.
- R6: After reset irq is 1. A hostLoad while running writes hostWrData into the buffer word and clears irq, unless a word boundary occurs in the same cycle. A hostLoad while not running writes hostWrData straight into the shifter, restarts the word and leaves irq unchanged.
- R7: In write mode (writeEn high), wrBit is sampled at the end of each bit period and shifted in most significant bit first. At a word boundary the completed word appears on hostRdData. rdBit is 0 whenever writeEn is high.
- R8: A rising edge on stepPulse while driveSel is high moves headTrack by one track. stepDirIn = 1 moves inward (+1, saturating at NUM_TRACKS-1) and stepDirIn = 0 moves outward (-1, saturating at 0). Edges while driveSel is low are ignored.
- R9: track0 is high exactly when headTrack is 0.
- R10: headSide equals sideSel delayed by one clock cycle.
- R11: Reset gives headTrack = 0, bitPos = 0, rdBit = 0, hostRdData = 0 and headSide = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| motorOn | input | 1 | Spindle motor enable |
| driveSel | input | 1 | Drive select |
| sideSel | input | 1 | Head side select |
| writeEn | input | 1 | Write mode when high, read mode when low |
| stepPulse | input | 1 | Head step; acts on rising edge |
| stepDirIn | input | 1 | Step direction, 1 = inward |
| wrBit | input | 1 | Write data bit from the controller |
| rdBit | output | 1 | Read data bit to the controller |
| index | output | 1 | Once-per-revolution index pulse |
| track0 | output | 1 | Head is at track 0 |
| headTrack | output | TRK_W | Current head track number |
| headSide | output | 1 | Registered side select, for the host |
| bitPos | output | POS_W | Current bit position on the track |
| hostWrData | input | REG_BITS | Word written by the host |
| hostLoad | input | 1 | Host write strobe for hostWrData |
| hostRdData | output | REG_BITS | Last word captured in write mode |
| irq | output | 1 | Host service request |

## Verification
The hardest condition to reach is a continuous read stream in which word boundaries, host refills and a track wrap interleave over several words. Any slip in when the buffer is handed over, or in where the wrap falls, shows up only as a misplaced bit many periods later. The bench makes this reachable with small overrides: a four-cycle bit, an eight-bit word and a twenty-bit track. A driver refills the buffer on each request while a monitor compares every streamed bit, its track position and the index level against a queue. Write capture, select gating and saturating head movement are then driven in short directed sequences.

// File: rtl/floppy_stream_pkg.sv
package floppy_stream_pkg;
  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic bitTick;  // a bit period ends this cycle
    logic wordEnd;  // last bit of the interchange word ends this cycle
    logic prime;    // host load while stopped: fill shifter directly
    logic stepIn;   // move head one track inward
    logic stepOut;  // move head one track outward
  } strobes_t;
endpackage

// File: rtl/floppy_stream_ctrl.sv
module floppy_stream_ctrl
  import floppy_stream_pkg::*;
#(
  parameter int CYCLES_PER_BIT = 128,
  parameter int TRACK_BITS     = 50000,
  parameter int REG_BITS       = 128,
  parameter int INDEX_BITS     = 16,
  parameter int NUM_TRACKS     = 84,
  localparam int DIV_W  = $clog2(CYCLES_PER_BIT + 1),
  localparam int POS_W  = $clog2(TRACK_BITS + 1),
  localparam int WORD_W = $clog2(REG_BITS + 1),
  localparam int TRK_W  = $clog2(NUM_TRACKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             motorOn,
  input  logic             driveSel,
  input  logic             stepPulse,
  input  logic             stepDirIn,
  input  logic             hostLoad,
  input  logic [TRK_W-1:0] headTrack,
  output strobes_t         strb,
  output logic [POS_W-1:0] bitPos,
  output logic             index
);
  localparam logic [POS_W-1:0]  LAST_POS   = POS_W'(TRACK_BITS - 1);
  localparam logic [WORD_W-1:0] LAST_WBIT  = WORD_W'(REG_BITS - 1);
  localparam logic [TRK_W-1:0]  LAST_TRACK = TRK_W'(NUM_TRACKS - 1);
  localparam logic [POS_W-1:0]  IDX_LEN    = POS_W'(INDEX_BITS);

  logic running;
  logic tick;
  logic [WORD_W-1:0] wordCnt;
  logic stepPrev;
  logic stepEdge;

  assign running = motorOn & driveSel;

  // Bit-period divider; a divisor of one needs no counter
  generate
    if (CYCLES_PER_BIT == 1) begin : g_noDiv
      assign tick = running;
    end else begin : g_div
      localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(CYCLES_PER_BIT - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !running)    divCnt <= '0;
        else if (divCnt == LAST_DIV) divCnt <= '0;
        else                      divCnt <= divCnt + 1'b1;
      end
      assign tick = running && (divCnt == LAST_DIV);
    end
  endgenerate

  // Track position and word bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitPos  <= '0;
      wordCnt <= '0;
      stepPrev <= 1'b0;
    end else begin
      stepPrev <= stepPulse;
      if (tick) bitPos <= (bitPos == LAST_POS) ? '0 : bitPos + 1'b1;
      if (strb.prime)   wordCnt <= '0;
      else if (tick)    wordCnt <= (wordCnt == LAST_WBIT) ? '0 : wordCnt + 1'b1;
    end
  end

  assign stepEdge = stepPulse & ~stepPrev & driveSel;

  always_comb begin
    strb.bitTick = tick;
    strb.wordEnd = tick && (wordCnt == LAST_WBIT);
    strb.prime   = hostLoad && !running;
    strb.stepIn  = stepEdge && stepDirIn && (headTrack != LAST_TRACK);
    strb.stepOut = stepEdge && !stepDirIn && (headTrack != '0);
  end

  assign index = running && (bitPos < IDX_LEN);
endmodule

// File: rtl/floppy_stream_dp.sv
module floppy_stream_dp
  import floppy_stream_pkg::*;
#(
  parameter int REG_BITS   = 128,
  parameter int NUM_TRACKS = 84,
  localparam int TRK_W = $clog2(NUM_TRACKS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strb,
  input  logic                writeEn,
  input  logic                wrBit,
  input  logic                sideSel,
  input  logic                hostLoad,
  input  logic [REG_BITS-1:0] hostWrData,
  output logic [REG_BITS-1:0] hostRdData,
  output logic                rdBit,
  output logic                irq,
  output logic [TRK_W-1:0]    headTrack,
  output logic                headSide,
  output logic                track0
);
  logic [REG_BITS-1:0] shiftReg;
  logic [REG_BITS-1:0] bufWord;
  logic                inBit;

  assign inBit = writeEn ? wrBit : 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      bufWord    <= '0;
      hostRdData <= '0;
      irq        <= 1'b1;
      headTrack  <= '0;
      headSide   <= 1'b0;
    end else begin
      headSide <= sideSel;

      if (strb.stepIn)       headTrack <= headTrack + 1'b1;
      else if (strb.stepOut) headTrack <= headTrack - 1'b1;

      if (strb.prime) begin
        shiftReg <= hostWrData;
      end else if (strb.wordEnd) begin
        if (writeEn) hostRdData <= {shiftReg[REG_BITS-2:0], wrBit};
        shiftReg <= bufWord;
      end else if (strb.bitTick) begin
        shiftReg <= {shiftReg[REG_BITS-2:0], inBit};
      end

      if (hostLoad && !strb.prime) bufWord <= hostWrData;

      if (strb.wordEnd)                  irq <= 1'b1;
      else if (hostLoad && !strb.prime)  irq <= 1'b0;
    end
  end

  assign rdBit  = !writeEn && shiftReg[REG_BITS-1];
  assign track0 = (headTrack == '0);
endmodule

// File: rtl/floppy_bit_streamer.sv
module floppy_bit_streamer
  import floppy_stream_pkg::*;
#(
  parameter int CYCLES_PER_BIT = 128,
  parameter int TRACK_BITS     = 50000,
  parameter int REG_BITS       = 128,
  parameter int INDEX_BITS     = 16,
  parameter int NUM_TRACKS     = 84,
  localparam int POS_W = $clog2(TRACK_BITS + 1),
  localparam int TRK_W = $clog2(NUM_TRACKS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                motorOn,
  input  logic                driveSel,
  input  logic                sideSel,
  input  logic                writeEn,
  input  logic                stepPulse,
  input  logic                stepDirIn,
  input  logic                wrBit,
  output logic                rdBit,
  output logic                index,
  output logic                track0,
  output logic [TRK_W-1:0]    headTrack,
  output logic                headSide,
  output logic [POS_W-1:0]    bitPos,
  input  logic [REG_BITS-1:0] hostWrData,
  input  logic                hostLoad,
  output logic [REG_BITS-1:0] hostRdData,
  output logic                irq
);
  strobes_t strb;

  floppy_stream_ctrl #(
    .CYCLES_PER_BIT(CYCLES_PER_BIT), .TRACK_BITS(TRACK_BITS),
    .REG_BITS(REG_BITS), .INDEX_BITS(INDEX_BITS), .NUM_TRACKS(NUM_TRACKS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .motorOn(motorOn), .driveSel(driveSel),
    .stepPulse(stepPulse), .stepDirIn(stepDirIn), .hostLoad(hostLoad),
    .headTrack(headTrack), .strb(strb), .bitPos(bitPos), .index(index)
  );

  floppy_stream_dp #(
    .REG_BITS(REG_BITS), .NUM_TRACKS(NUM_TRACKS)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .writeEn(writeEn), .wrBit(wrBit),
    .sideSel(sideSel), .hostLoad(hostLoad), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .rdBit(rdBit), .irq(irq),
    .headTrack(headTrack), .headSide(headSide), .track0(track0)
  );
endmodule

// File: rtl/floppy_bit_streamer_chk.sv
module floppy_bit_streamer_chk #(
  parameter int TRACK_BITS = 50000,
  parameter int NUM_TRACKS = 84,
  localparam int POS_W = $clog2(TRACK_BITS + 1),
  localparam int TRK_W = $clog2(NUM_TRACKS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             motorOn,
  input logic             driveSel,
  input logic             hostLoad,
  input logic             wordEnd,
  input logic             irq,
  input logic [POS_W-1:0] bitPos,
  input logic [TRK_W-1:0] headTrack
);
  localparam logic [POS_W-1:0] LAST_POS   = POS_W'(TRACK_BITS - 1);
  localparam logic [TRK_W-1:0] LAST_TRACK = TRK_W'(NUM_TRACKS - 1);

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitPos <= LAST_POS); // R3
  AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    bitPos != $past(bitPos) |-> (bitPos == $past(bitPos) + 1'b1) || (bitPos == '0 && $past(bitPos) == LAST_POS)); // R3
  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !(motorOn && driveSel) |=> $stable(bitPos)); // R2
  AST_HEAD_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    headTrack <= LAST_TRACK); // R8
  AST_HEAD_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (headTrack == $past(headTrack)) || (headTrack == $past(headTrack) + 1'b1) || (headTrack + 1'b1 == $past(headTrack))); // R8
  AST_WORD_END_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    wordEnd |=> irq); // R5
  AST_LOAD_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    hostLoad && motorOn && driveSel && !wordEnd |=> !irq); // R6
endmodule

bind floppy_bit_streamer floppy_bit_streamer_chk #(
  .TRACK_BITS(TRACK_BITS), .NUM_TRACKS(NUM_TRACKS)
) chkInst (
  .clk(clk), .rstN(rstN), .motorOn(motorOn), .driveSel(driveSel),
  .hostLoad(hostLoad), .wordEnd(strb.wordEnd), .irq(irq),
  .bitPos(bitPos), .headTrack(headTrack)
);

// File: tb/floppy_bit_streamer_test.sv
module floppy_bit_streamer_test;
  localparam int CPB   = 4;
  localparam int TB    = 20;
  localparam int RB    = 8;
  localparam int IDX   = 2;
  localparam int NT    = 4;
  localparam int POS_W = $clog2(TB + 1);
  localparam int TRK_W = $clog2(NT + 1);
  localparam int NBITS = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic motorOn = 1'b0, driveSel = 1'b0, sideSel = 1'b0, writeEn = 1'b0;
  logic stepPulse = 1'b0, stepDirIn = 1'b0, wrBit = 1'b0, hostLoad = 1'b0;
  logic [RB-1:0] hostWrData = '0;
  logic rdBit, index, track0, headSide, irq;
  logic [TRK_W-1:0] headTrack;
  logic [POS_W-1:0] bitPos;
  logic [RB-1:0] hostRdData;

  int errors = 0;
  int checks = 0;
  logic expQ[$];
  event startEv;
  bit monDone = 0;
  int expTrack = 0;

  always #2 clk = ~clk;

  floppy_bit_streamer #(
    .CYCLES_PER_BIT(CPB), .TRACK_BITS(TB), .REG_BITS(RB),
    .INDEX_BITS(IDX), .NUM_TRACKS(NT)
  ) uut (
    .clk(clk), .rstN(rstN), .motorOn(motorOn), .driveSel(driveSel),
    .sideSel(sideSel), .writeEn(writeEn), .stepPulse(stepPulse),
    .stepDirIn(stepDirIn), .wrBit(wrBit), .rdBit(rdBit), .index(index),
    .track0(track0), .headTrack(headTrack), .headSide(headSide),
    .bitPos(bitPos), .hostWrData(hostWrData), .hostLoad(hostLoad),
    .hostRdData(hostRdData), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pushWord(input logic [RB-1:0] w);
    for (int b = RB - 1; b >= 0; b--) expQ.push_back(w[b]);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic stepOnce(input logic dir);
    stepDirIn = dir;
    stepPulse = 1'b1;
    repeat (2) @(negedge clk);
    stepPulse = 1'b0;
    repeat (2) @(negedge clk);
    if (driveSel) begin
      if (dir && expTrack < NT - 1) expTrack++;
      else if (!dir && expTrack > 0) expTrack--;
    end
    chk("R8 head track", int'(headTrack), expTrack);
    chk("R9 track0", int'(track0), int'(expTrack == 0));
  endtask

  // Monitor: one sample per bit period, mid-period
  initial begin
    @(startEv);
    for (int i = 0; i < NBITS; i++) begin
      if (i == 0) @(posedge clk);
      else repeat (CPB) @(posedge clk);
      @(negedge clk);
      if (expQ.size() == 0) begin
        errors++; checks++;
        $display("FAIL R1: actual=empty expected=queued bit %0d", i);
      end else begin
        chk("R1 read bit", int'(rdBit), int'(expQ.pop_front()));
      end
      chk("R3 bit position", int'(bitPos), i % TB);
      chk("R4 index", int'(index), int'((i % TB) < IDX));
    end
    monDone = 1;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [RB-1:0] pat;
    doReset();
    @(negedge clk);
    // R11 reset state
    chk("R11 head track", int'(headTrack), 0);
    chk("R11 bit position", int'(bitPos), 0);
    chk("R11 rdBit", int'(rdBit), 0);
    chk("R11 hostRdData", int'(hostRdData), 0);
    chk("R6 irq after reset", int'(irq), 1);
    chk("R9 track0 at reset", int'(track0), 1);
    chk("R4 index while stopped", int'(index), 0);

    // R6 prime while stopped: irq unchanged
    hostWrData = 8'hA5; hostLoad = 1'b1; pushWord(8'hA5);
    @(negedge clk);
    hostLoad = 1'b0;
    @(negedge clk);
    chk("R6 prime leaves irq", int'(irq), 1);
    chk("R1 first bit visible after prime", int'(rdBit), 1);

    // Start streaming and load buffer at the same time
    motorOn = 1'b1; driveSel = 1'b1;
    hostWrData = 8'h3C; hostLoad = 1'b1; pushWord(8'h3C);
    -> startEv;
    @(negedge clk);
    hostLoad = 1'b0;
    chk("R6 running load clears irq", int'(irq), 0);
    foreach (pat[k]) pat[k] = 1'b0;
    for (int w = 0; w < 2; w++) begin
      pat = (w == 0) ? 8'hE1 : 8'h5A;
      do @(negedge clk); while (!irq);
      checks++; // R5 request seen at a word boundary
      hostWrData = pat; hostLoad = 1'b1; pushWord(pat);
      @(negedge clk);
      hostLoad = 1'b0;
    end
    wait (monDone);
    motorOn = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 frozen after stop", int'(bitPos), 31 % TB);
    chk("R5 irq at last boundary", int'(irq), 1);
    chk("R4 index low when stopped", int'(index), 0);

    // R2 motor on but drive deselected
    motorOn = 1'b1; driveSel = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2 deselected frozen", int'(bitPos), 31 % TB);

    // R10 side select
    sideSel = 1'b1;
    @(negedge clk);
    chk("R10 headSide", int'(headSide), 1);
    sideSel = 1'b0;
    @(negedge clk);
    chk("R10 headSide low", int'(headSide), 0);

    // R8 / R9 stepping
    driveSel = 1'b1; motorOn = 1'b0;
    for (int s = 0; s < 5; s++) stepOnce(1'b1);
    driveSel = 1'b0;
    stepOnce(1'b0);
    driveSel = 1'b1;
    for (int s = 0; s < 4; s++) stepOnce(1'b0);

    // R7 write capture
    doReset();
    @(negedge clk);
    pat = 8'hB2;
    motorOn = 1'b1; driveSel = 1'b1; writeEn = 1'b1;
    hostLoad = 1'b1; wrBit = pat[RB-1];
    @(negedge clk);
    hostLoad = 1'b0;
    chk("R6 irq cleared for write", int'(irq), 0);
    repeat (CPB - 1) @(posedge clk);
    @(negedge clk);
    for (int i = 1; i < RB; i++) begin
      wrBit = pat[RB-1-i];
      chk("R7 rdBit low in write", int'(rdBit), 0);
      repeat (CPB) @(posedge clk);
      @(negedge clk);
      if (i == RB - 2) chk("R5 no irq before boundary", int'(irq), 0);
    end
    chk("R7 captured word", int'(hostRdData), int'(pat));
    chk("R5 irq at write boundary", int'(irq), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule